// File: doc/BRIEF.md
# Two-Sided Page Translation Lookaside Buffer with Ordered Protection Checks

This block translates 32-bit virtual addresses to physical addresses through two small caches of page mappings. One cache serves instruction fetches and the other serves data reads and writes. Pages are 8 KB. Each cache is set-associative, 4 ways by 16 entries by default. The entry index is taken from the low bits of the virtual page number, and every way at that index is compared at once.

Each entry is two 32-bit words. The upper word carries the page tag and the owning process ID. The lower word carries the physical frame and five flags: global, valid, kernel-only, writable and executable. A lookup supplies the address, the access kind, a user-mode flag, the current process ID and four per-flag enable bits. The result arrives one cycle later. It gives the physical address, the granted permissions, a miss flag and an exception vector number.

The vector number identifies the first failing check. The checks run in a fixed order: tag or process ID, then kernel-only, then write, then execute, then valid. On a tag hit, the matching entry's words are captured. On any failure, a cause word and a select word are captured for the refill handler. A separate write port loads entries by side, way and index.

Top module: `tlb_xlate`

## Requirements
- R1: `rs_valid` is high in exactly the cycle after a cycle in which `lk_valid` was high. All result outputs update only at that edge.
- R2: The index is `lk_vaddr[16:13]`. A way hits when `hi[31:13]` equals `lk_vaddr[31:13]`, and the lowest-numbered hitting way is used. `lk_kind` 2 (execute) selects the instruction side. Kinds 0 (read), 1 (write) and 3 (treated as read) select the data side. `rs_paddr` is `{lo[31:13], lk_vaddr[12:0]}` on a tag hit and `{19'b0, lk_vaddr[12:0]}` on a tag miss, and `rs_pfn` follows the same rule.
- R3: The vector base is 4 on the instruction side and 8 on the data side. A tag miss faults with the base. A hit on an entry with `lo[4]`=0 (not global) whose `hi[7:0]` differs from `lk_pid` also faults with the base. This check comes before all others.
- R4: If `lk_chk_en[2]`, `lo[2]` (kernel-only) and `lk_user` are all set, the lookup faults with base+2. This takes priority over the write, execute and valid checks.
- R5: A write (kind 1) with `lk_chk_en[3]` set to an entry with `lo[1]`=0 faults with base+3. This takes priority over the valid check.
- R6: An execute (kind 2) with `lk_chk_en[1]` set to an entry with `lo[0]`=0 faults with base+3. This takes priority over the valid check.
- R7: If `lk_chk_en[0]` is set and `lo[3]`=0 (not valid), the lookup faults with base+1.
- R8: A lookup that passes every check has `rs_miss`=0, `rs_vector` equal to the base, and `rs_perm` = {`lo[0]`, `lo[1]`, 1} (execute, write, read). Any fault gives `rs_perm`=0 and `rs_miss`=1.
- R9: On every tag hit, faulting or not, `tlb_hi_q`/`tlb_lo_q` take the hit entry's words. On a tag miss they hold their values.
- R10: On a fault, `select_q` becomes the index, zero-extended. The way field is zero. `cause_q` becomes `{vaddr[31:13], 3'b000, lk_kind, lk_pid}`. On success both hold their values.
- R11: A write through `wr_*` is visible to lookups from the next cycle onward. A lookup in the same cycle as a write to its own entry sees the old contents.
- R12: A synchronous active-low reset clears every entry, every captured register and every result output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address |
| lk_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| lk_user | input | 1 | Access made in user mode |
| lk_pid | input | 8 | Current process ID |
| lk_chk_en | input | 4 | Check enables {write, kernel, execute, valid} |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | 0 instruction side, 1 data side |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Index to write |
| wr_hi | input | 32 | Upper entry word |
| wr_lo | input | 32 | Lower entry word |
| rs_valid | output | 1 | Result valid |
| rs_miss | output | 1 | Lookup faulted |
| rs_vector | output | 4 | Exception vector number |
| rs_perm | output | 3 | Granted {execute, write, read} |
| rs_pfn | output | 19 | Physical frame number |
| rs_paddr | output | 32 | Physical address |
| tlb_hi_q | output | 32 | Upper word of last hit entry |
| tlb_lo_q | output | 32 | Lower word of last hit entry |
| select_q | output | 32 | Index of last faulting lookup |
| cause_q | output | 32 | Tag, kind and process ID of last fault |

## Verification
An entry write and a lookup can land in the same cycle, including on the very entry being looked up. The bench provokes this both in directed steps and at random, aiming the write at the looked-up index. It expects the lookup to return the pre-write mapping and the next lookup to return the new one. Each priority pair is also forced directly: a single entry fails several checks at once, and the reported vector must be that of the earliest check in the order.

// File: rtl/tlb_xlate_pkg.sv
// Shared constants for the two-sided page translation buffer.
// Assumes 32-bit virtual addresses and 8 KB pages.
package tlb_xlate_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 13;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int PID_W      = 8;

    // Access kinds seen at the lookup port
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    // Flag positions in the lower entry word
    localparam int FL_GLOBAL = 4;
    localparam int FL_VALID  = 3;
    localparam int FL_KERNEL = 2;
    localparam int FL_WRITE  = 1;
    localparam int FL_EXEC   = 0;

    // Positions inside the 4-bit check-enable input
    localparam int EN_WRITE  = 3;
    localparam int EN_KERNEL = 2;
    localparam int EN_EXEC   = 1;
    localparam int EN_VALID  = 0;

    // Vector bases and offsets
    localparam logic [3:0] VEC_BASE_INSN = 4'd4;
    localparam logic [3:0] VEC_BASE_DATA = 4'd8;
    localparam logic [1:0] OFF_REFILL    = 2'd0;
    localparam logic [1:0] OFF_INVALID   = 2'd1;
    localparam logic [1:0] OFF_ACCESS    = 2'd2;
    localparam logic [1:0] OFF_PROTECT   = 2'd3;
endpackage

// File: rtl/tlb_entry_bank.sv
// Entry storage for one side: WAYS x SETS pairs of 32-bit words.
// Reads are combinational at rd_idx; writes land at the clock edge,
// so a read in the write cycle returns the previous contents.
module tlb_entry_bank #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [31:0]                 wr_hi,
    input  logic [31:0]                 wr_lo,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0][31:0]       rd_hi,
    output logic [WAYS-1:0][31:0]       rd_lo
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [31:0] hi_q [SETS];
        logic [31:0] lo_q [SETS];

        // Clear on reset, else store the addressed entry of this way
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    hi_q[s] <= '0;
                    lo_q[s] <= '0;
                end
            end else if (wr_en && (wr_way == WAY_W'(w))) begin
                hi_q[wr_idx] <= wr_hi;
                lo_q[wr_idx] <= wr_lo;
            end
        end

        assign rd_hi[w] = hi_q[rd_idx];
        assign rd_lo[w] = lo_q[rd_idx];
    end
endmodule

// File: rtl/tlb_way_match.sv
// Compares the tag of every way at one index against the lookup page
// number and forwards the words of the lowest-numbered hit.
module tlb_way_match
    import tlb_xlate_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0][31:0] way_hi,
    input  logic [WAYS-1:0][31:0] way_lo,
    input  logic [VPN_W-1:0]      vpn,
    output logic                  hit,
    output logic [31:0]           hit_hi,
    output logic [31:0]           hit_lo
);
    // Scan from the top way down so the lowest match is kept last
    always_comb begin
        hit    = 1'b0;
        hit_hi = '0;
        hit_lo = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hi[w][VA_W-1:PAGE_SHIFT] == vpn) begin
                hit    = 1'b1;
                hit_hi = way_hi[w];
                hit_lo = way_lo[w];
            end
        end
    end
endmodule

// File: rtl/tlb_perm_check.sv
// Applies the ordered checks to the hit entry: owner, kernel-only,
// write, execute, valid. Emits the vector offset of the first failure
// and the granted permission bits on success.
module tlb_perm_check
    import tlb_xlate_pkg::*;
(
    input  logic             hit,
    input  logic [PID_W-1:0] ent_pid,
    input  logic [4:0]       ent_flags,
    input  acc_kind_e        kind,
    input  logic             user,
    input  logic [PID_W-1:0] pid,
    input  logic [3:0]       chk_en,
    output logic             fault,
    output logic [1:0]       vec_off,
    output logic [2:0]       perm
);
    logic owner_ok;

    assign owner_ok = ent_flags[FL_GLOBAL] || (ent_pid == pid);

    // Priority chain; the first failing check decides the offset
    always_comb begin
        fault   = 1'b1;
        vec_off = OFF_REFILL;
        perm    = 3'b000;
        if (!hit || !owner_ok) begin
            vec_off = OFF_REFILL;
        end else if (chk_en[EN_KERNEL] && ent_flags[FL_KERNEL] && user) begin
            vec_off = OFF_ACCESS;
        end else if (kind == ACC_WRITE && chk_en[EN_WRITE] && !ent_flags[FL_WRITE]) begin
            vec_off = OFF_PROTECT;
        end else if (kind == ACC_EXEC && chk_en[EN_EXEC] && !ent_flags[FL_EXEC]) begin
            vec_off = OFF_PROTECT;
        end else if (chk_en[EN_VALID] && !ent_flags[FL_VALID]) begin
            vec_off = OFF_INVALID;
        end else begin
            fault = 1'b0;
            perm  = {ent_flags[FL_EXEC], ent_flags[FL_WRITE], 1'b1};
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
// Top of the two-sided translation buffer. Execute lookups use the
// instruction bank, all other kinds the data bank. The result, the
// captured entry words and the fault records are registered, giving
// one cycle of latency. Assumes SETS is a power of two and at most 2^19.
module tlb_xlate
    import tlb_xlate_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic [1:0]        lk_kind,
    input  logic              lk_user,
    input  logic [7:0]        lk_pid,
    input  logic [3:0]        lk_chk_en,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_hi,
    input  logic [31:0]       wr_lo,
    output logic              rs_valid,
    output logic              rs_miss,
    output logic [3:0]        rs_vector,
    output logic [2:0]        rs_perm,
    output logic [18:0]       rs_pfn,
    output logic [31:0]       rs_paddr,
    output logic [31:0]       tlb_hi_q,
    output logic [31:0]       tlb_lo_q,
    output logic [31:0]       select_q,
    output logic [31:0]       cause_q
);
    logic [1:0][WAYS-1:0][31:0] bank_hi;
    logic [1:0][WAYS-1:0][31:0] bank_lo;
    logic [VPN_W-1:0]           vpn;
    logic [IDX_W-1:0]           idx;
    logic                       is_insn;
    logic                       hit;
    logic [31:0]                hit_hi;
    logic [31:0]                hit_lo;
    logic                       fault;
    logic [1:0]                 vec_off;
    logic [2:0]                 perm;
    logic [VPN_W-1:0]           pfn;
    logic [3:0]                 vec_base;

    assign vpn      = lk_vaddr[VA_W-1:PAGE_SHIFT];
    assign idx      = lk_vaddr[PAGE_SHIFT +: IDX_W];
    assign is_insn  = (lk_kind == 2'(ACC_EXEC));
    assign vec_base = is_insn ? VEC_BASE_INSN : VEC_BASE_DATA;
    assign pfn      = hit ? hit_lo[VA_W-1:PAGE_SHIFT] : '0;

    // Side 0 holds instruction mappings, side 1 data mappings
    for (genvar s = 0; s < 2; s++) begin : g_side
        tlb_entry_bank #(.WAYS(WAYS), .SETS(SETS)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en && (wr_side == 1'(s))),
            .wr_way (wr_way),
            .wr_idx (wr_idx),
            .wr_hi  (wr_hi),
            .wr_lo  (wr_lo),
            .rd_idx (idx),
            .rd_hi  (bank_hi[s]),
            .rd_lo  (bank_lo[s])
        );
    end

    tlb_way_match #(.WAYS(WAYS)) u_match (
        .way_hi (is_insn ? bank_hi[0] : bank_hi[1]),
        .way_lo (is_insn ? bank_lo[0] : bank_lo[1]),
        .vpn    (vpn),
        .hit    (hit),
        .hit_hi (hit_hi),
        .hit_lo (hit_lo)
    );

    tlb_perm_check u_check (
        .hit       (hit),
        .ent_pid   (hit_hi[PID_W-1:0]),
        .ent_flags (hit_lo[4:0]),
        .kind      (acc_kind_e'(lk_kind)),
        .user      (lk_user),
        .pid       (lk_pid),
        .chk_en    (lk_chk_en),
        .fault     (fault),
        .vec_off   (vec_off),
        .perm      (perm)
    );

    // Register the lookup result and update the captured records
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid  <= 1'b0;
            rs_miss   <= 1'b0;
            rs_vector <= '0;
            rs_perm   <= '0;
            rs_pfn    <= '0;
            rs_paddr  <= '0;
            tlb_hi_q  <= '0;
            tlb_lo_q  <= '0;
            select_q  <= '0;
            cause_q   <= '0;
        end else begin
            rs_valid <= lk_valid;
            if (lk_valid) begin
                rs_miss   <= fault;
                rs_vector <= vec_base + {2'b00, vec_off};
                rs_perm   <= perm;
                rs_pfn    <= pfn;
                rs_paddr  <= {pfn, lk_vaddr[PAGE_SHIFT-1:0]};
                if (hit) begin
                    tlb_hi_q <= hit_hi;
                    tlb_lo_q <= hit_lo;
                end
                if (fault) begin
                    select_q <= 32'(idx);
                    cause_q  <= {vpn, 3'b000, lk_kind, lk_pid};
                end
            end
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
// Assertion checker for tlb_xlate, attached by bind. Observes ports only.
module tlb_xlate_chk #(
    parameter int IDX_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [31:0] lk_vaddr,
    input logic [1:0]  lk_kind,
    input logic [7:0]  lk_pid,
    input logic        rs_valid,
    input logic        rs_miss,
    input logic [3:0]  rs_vector,
    input logic [2:0]  rs_perm,
    input logic [31:0] rs_paddr,
    input logic [31:0] select_q,
    input logic [31:0] cause_q
);
    assert_result_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);

    assert_page_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_paddr[12:0] == $past(lk_vaddr[12:0]));

    assert_vector_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_vector[3:2] == (($past(lk_kind) == 2'd2) ? 2'b01 : 2'b10));

    assert_read_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_miss) |-> rs_perm[0]);

    assert_fault_no_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_miss) |-> rs_perm == 3'b000);

    assert_fault_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_miss) |-> select_q == 32'($past(lk_vaddr[13 +: IDX_W])));

    assert_fault_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_miss) |->
            cause_q == {$past(lk_vaddr[31:13]), 3'b000, $past(lk_kind), $past(lk_pid)});

    assert_success_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_miss) |-> ($stable(select_q) && $stable(cause_q)));
endmodule

bind tlb_xlate tlb_xlate_chk #(.IDX_W($clog2(SETS))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .lk_kind   (lk_kind),
    .lk_pid    (lk_pid),
    .rs_valid  (rs_valid),
    .rs_miss   (rs_miss),
    .rs_vector (rs_vector),
    .rs_perm   (rs_perm),
    .rs_paddr  (rs_paddr),
    .select_q  (select_q),
    .cause_q   (cause_q)
);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [1:0]  lk_kind;
    logic        lk_user;
    logic [7:0]  lk_pid;
    logic [3:0]  lk_chk_en;
    logic        wr_en;
    logic        wr_side;
    logic [1:0]  wr_way;
    logic [3:0]  wr_idx;
    logic [31:0] wr_hi;
    logic [31:0] wr_lo;
    logic        rs_valid;
    logic        rs_miss;
    logic [3:0]  rs_vector;
    logic [2:0]  rs_perm;
    logic [18:0] rs_pfn;
    logic [31:0] rs_paddr;
    logic [31:0] tlb_hi_q;
    logic [31:0] tlb_lo_q;
    logic [31:0] select_q;
    logic [31:0] cause_q;

    always #2 clk = ~clk;

    tlb_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kind(lk_kind), .lk_user(lk_user), .lk_pid(lk_pid), .lk_chk_en(lk_chk_en),
        .wr_en(wr_en), .wr_side(wr_side), .wr_way(wr_way), .wr_idx(wr_idx),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .rs_valid(rs_valid), .rs_miss(rs_miss),
        .rs_vector(rs_vector), .rs_perm(rs_perm), .rs_pfn(rs_pfn), .rs_paddr(rs_paddr),
        .tlb_hi_q(tlb_hi_q), .tlb_lo_q(tlb_lo_q), .select_q(select_q), .cause_q(cause_q)
    );

    int total = 0;
    int bad   = 0;

    // Reference entry contents [side][way][index]; side 0 = instruction
    logic [31:0] m_hi [2][4][16];
    logic [31:0] m_lo [2][4][16];
    logic [31:0] e_hi_q, e_lo_q, e_sel, e_cause;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Expected result computed from the requirement text
    task automatic model(input logic [31:0] va, input logic [1:0] kind,
                         input logic user, input logic [7:0] pid, input logic [3:0] en,
                         output logic miss, output logic [3:0] vec,
                         output logic [2:0] perm, output logic [31:0] pa);
        int side = (kind == 2'd2) ? 0 : 1;
        int idx  = int'(va[16:13]);
        logic [3:0] base = (side == 0) ? 4'd4 : 4'd8;
        logic found = 1'b0;
        logic [31:0] h = 0, l = 0;
        for (int w = 3; w >= 0; w--)
            if (m_hi[side][w][idx][31:13] == va[31:13]) begin
                found = 1'b1; h = m_hi[side][w][idx]; l = m_lo[side][w][idx];
            end
        miss = 1'b1; perm = 3'b000; vec = base;
        if (!found || (!l[4] && h[7:0] != pid)) vec = base;
        else if (en[2] && l[2] && user) vec = base + 4'd2;
        else if (kind == 2'd1 && en[3] && !l[1]) vec = base + 4'd3;
        else if (kind == 2'd2 && en[1] && !l[0]) vec = base + 4'd3;
        else if (en[0] && !l[3]) vec = base + 4'd1;
        else begin miss = 1'b0; perm = {l[0], l[1], 1'b1}; end
        pa = found ? {l[31:13], va[12:0]} : {19'd0, va[12:0]};
        if (found) begin e_hi_q = h; e_lo_q = l; end
        if (miss) begin
            e_sel = {28'd0, va[16:13]};
            e_cause = {va[31:13], 3'b000, kind, pid};
        end
    endtask

    task automatic write_entry(input logic s, input logic [1:0] w, input logic [3:0] i,
                               input logic [31:0] h, input logic [31:0] l);
        @(negedge clk);
        wr_en = 1'b1; wr_side = s; wr_way = w; wr_idx = i; wr_hi = h; wr_lo = l;
        @(negedge clk);
        wr_en = 1'b0;
        m_hi[s][w][i] = h; m_lo[s][w][i] = l;
    endtask

    // One lookup, optionally with an entry write in the same cycle (R11)
    task automatic lookup(input string req, input logic [31:0] va, input logic [1:0] kind,
                          input logic user, input logic [7:0] pid, input logic [3:0] en,
                          input logic do_wr, input logic s, input logic [1:0] w,
                          input logic [3:0] i, input logic [31:0] h, input logic [31:0] l);
        logic miss; logic [3:0] vec; logic [2:0] perm; logic [31:0] pa;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind; lk_user = user;
        lk_pid = pid; lk_chk_en = en;
        wr_en = do_wr; wr_side = s; wr_way = w; wr_idx = i; wr_hi = h; wr_lo = l;
        model(va, kind, user, pid, en, miss, vec, perm, pa);
        @(negedge clk);
        lk_valid = 1'b0; wr_en = 1'b0;
        if (do_wr) begin m_hi[s][w][i] = h; m_lo[s][w][i] = l; end
        chk({req, " R1"}, "rs_valid", 32'(rs_valid), 32'd1);
        chk(req, "rs_miss", 32'(rs_miss), 32'(miss));
        chk(req, "rs_vector", 32'(rs_vector), 32'(vec));
        chk({req, " R8"}, "rs_perm", 32'(rs_perm), 32'(perm));
        chk({req, " R2"}, "rs_paddr", rs_paddr, pa);
        chk({req, " R2"}, "rs_pfn", 32'(rs_pfn), 32'(pa[31:13]));
        chk({req, " R9"}, "tlb_hi_q", tlb_hi_q, e_hi_q);
        chk({req, " R9"}, "tlb_lo_q", tlb_lo_q, e_lo_q);
        chk({req, " R10"}, "select_q", select_q, e_sel);
        chk({req, " R10"}, "cause_q", cause_q, e_cause);
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic [1:0] kind,
                        input logic user, input logic [7:0] pid, input logic [3:0] en);
        lookup(req, va, kind, user, pid, en, 1'b0, 1'b0, 2'd0, 4'd0, 32'd0, 32'd0);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 4; w++)
                for (int i = 0; i < 16; i++) begin m_hi[s][w][i] = 0; m_lo[s][w][i] = 0; end
        e_hi_q = 0; e_lo_q = 0; e_sel = 0; e_cause = 0;
        rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = 0; lk_kind = 0; lk_user = 0;
        lk_pid = 0; lk_chk_en = 0; wr_en = 0; wr_side = 0; wr_way = 0; wr_idx = 0;
        wr_hi = 0; wr_lo = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state at the ports
        chk("R12", "rs_valid", 32'(rs_valid), 32'd0);
        chk("R12", "rs_paddr", rs_paddr, 32'd0);
        chk("R12", "cause_q", cause_q, 32'd0);
        chk("R12", "select_q", select_q, 32'd0);
        chk("R12", "tlb_lo_q", tlb_lo_q, 32'd0);
        // R12: cleared entries match page 0 with all-zero words
        look("R12", 32'h0000_0123, 2'd0, 1'b0, 8'd0, 4'b0000);
        look("R12", 32'h0000_0123, 2'd0, 1'b0, 8'd0, 4'b0001);

        // R2: two ways share a tag at index 5; way 1 must win over way 2
        write_entry(1'b1, 2'd2, 4'd5, {19'h12345, 5'd0, 8'h33}, {19'h0AAAA, 8'd0, 5'b11011});
        write_entry(1'b1, 2'd1, 4'd5, {19'h12345, 5'd0, 8'h33}, {19'h05555, 8'd0, 5'b01011});
        look("R2", {19'h12345, 13'h0ABC}, 2'd0, 1'b0, 8'h33, 4'b1111);
        // R3: owner mismatch on non-global way 1, and tag miss
        look("R3", {19'h12345, 13'h0001}, 2'd1, 1'b0, 8'h34, 4'b1111);
        look("R3", {19'h54325, 13'h0001}, 2'd0, 1'b0, 8'h33, 4'b0000);
        // Global entry ignores owner; kernel + not writable + invalid
        write_entry(1'b1, 2'd0, 4'd7, {19'h00017, 5'd0, 8'h01}, {19'h00ABC, 8'd0, 5'b10100});
        look("R4", {19'h00017, 13'h1FFF}, 2'd1, 1'b1, 8'h99, 4'b1111);
        look("R5", {19'h00017, 13'h0010}, 2'd1, 1'b0, 8'h99, 4'b1111);
        look("R7", {19'h00017, 13'h0010}, 2'd1, 1'b0, 8'h99, 4'b0111);
        look("R8", {19'h00017, 13'h0010}, 2'd1, 1'b1, 8'h99, 4'b0000);
        // R6: instruction side, not executable, invalid
        write_entry(1'b0, 2'd3, 4'd2, {19'h01232, 5'd0, 8'h05}, {19'h00777, 8'd0, 5'b00010});
        look("R6", {19'h01232, 13'h0004}, 2'd2, 1'b0, 8'h05, 4'b1111);
        look("R7", {19'h01232, 13'h0004}, 2'd2, 1'b0, 8'h05, 4'b0101);
        look("R8", {19'h01232, 13'h0004}, 2'd2, 1'b0, 8'h05, 4'b0000);
        // R2: same address through data side misses
        look("R2", {19'h01232, 13'h0004}, 2'd0, 1'b0, 8'h05, 4'b0000);
        // R11: lookup with a write to its own entry sees the old contents
        lookup("R11", {19'h00017, 13'h0020}, 2'd0, 1'b0, 8'h01, 4'b0001,
               1'b1, 1'b1, 2'd0, 4'd7, {19'h00017, 5'd0, 8'h01}, {19'h03030, 8'd0, 5'b01011});
        look("R11", {19'h00017, 13'h0020}, 2'd0, 1'b0, 8'h01, 4'b0001);

        // Random mix of fills, lookups and same-cycle writes
        for (int n = 0; n < 1500; n++) begin
            logic [3:0] ri = 4'($urandom % 16);
            logic [31:0] h = {15'($urandom % 4), ri, 5'd0, 8'($urandom % 2)};
            logic [31:0] l = {19'($urandom), 8'($urandom), 5'($urandom)};
            logic [31:0] va = {15'($urandom % 4), 4'($urandom % 16), 13'($urandom)};
            logic [1:0] k = 2'($urandom % 3);
            if ($urandom % 3 == 0)
                write_entry(1'($urandom), 2'($urandom), ri, h, l);
            else if ($urandom % 4 == 0)
                lookup("R11", va, k, 1'($urandom), 8'($urandom % 2), 4'($urandom),
                       1'b1, (k == 2'd2) ? 1'b0 : 1'b1, 2'($urandom), va[16:13],
                       {va[31:13], 5'd0, 8'($urandom % 2)}, l);
            else
                look("R3", va, k, 1'($urandom), 8'($urandom % 2), 4'($urandom));
        end
        // R1: idle cycle gives no result
        @(negedge clk);
        chk("R1", "rs_valid idle", 32'(rs_valid), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule